// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a translation miss by reading page-table entries from physical memory, one entry per read, with no translation applied to those reads. A miss carries a 20-bit virtual page number and a context number. The walker first reads the context table, at a base supplied on an input port, using the context number as the index. That entry gives the root of the level-1 table. From there the walker descends through up to three levels, using index fields of 8, 6 and 6 bits taken from the virtual page number.

Each fetched entry is typed by its two low bits. It either points to the next table or is a leaf translation. A leaf found at level 1 or level 2 ends the walk early and covers a larger region. In that case the low page-number bits that were not used as an index are copied from the virtual page number into the returned physical page number. Any entry that cannot continue the walk ends it with a fault pulse that names the level reached. A successful walk ends with a one-cycle refill pulse that carries the physical page number, the permission bits and the level of the leaf.

Top module: `pt_walker`

## Requirements
- R1: After reset `miss_ready` is 1 and `mem_req_valid`, `refill_valid` and `fault_valid` are 0.
- R2: Only one walk runs at a time. `miss_ready` is 0 from the cycle after a miss is accepted until the cycle of its refill or fault pulse. A `miss_valid` presented while `miss_ready` is 0 starts nothing and does not change the walk in progress.
- R3: The first read of every walk is at `ctx_table_base + miss_ctx*4`. The entry read there must have type 01 (pointer), or the walk faults with level 0.
- R4: Entry type is held in bits 1:0: 00 invalid, 01 pointer, 10 leaf, 11 reserved. A pointer's next table base is the entry with bits 1:0 cleared. The read at level L is at base + index*4, where level 1 uses VPN[19:12], level 2 uses VPN[11:6] and level 3 uses VPN[5:0].
- R5: An entry of type 00 or 11 at levels 1 to 3 ends the walk with a fault pulse whose `fault_level` is that level (1, 2 or 3).
- R6: A leaf at level 3 refills with `refill_ppn` = entry[31:12], `refill_perm` = entry[11:2] and `refill_level` = 3, after exactly four reads.
- R7: A leaf at level 1 returns {entry[31:24], VPN[11:0]} after two reads. A leaf at level 2 returns {entry[31:18], VPN[5:0]} after three reads. In both cases `refill_perm` = entry[11:2] and `refill_level` is the leaf's level.
- R8: A pointer entry fetched at level 3 ends the walk with a fault at level 3.
- R9: While `mem_req_ready` is 0, `mem_req_valid` and `mem_req_addr` hold steady. No new read is issued until the previous response has returned. Every read address is a multiple of 4.
- R10: `refill_valid` and `fault_valid` are single-cycle pulses. They are never high together, and exactly one of them ends each walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_table_base | input | 32 | Physical base address of the context table |
| miss_valid | input | 1 | Translation miss request |
| miss_ready | output | 1 | Walker idle; the miss is accepted when valid and ready are both 1 |
| miss_vpn | input | 20 | Virtual page number of the miss |
| miss_ctx | input | 8 | Context number of the miss |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Physical byte address of the 4-byte entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| refill_valid | output | 1 | Pulse: translation found |
| refill_ppn | output | 20 | Physical page number |
| refill_perm | output | 10 | Permission bits of the leaf |
| refill_level | output | 2 | Level at which the leaf was found |
| fault_valid | output | 1 | Pulse: walk ended without translation |
| fault_level | output | 2 | Level at which the walk stopped (0 is the context table) |

## Verification
The hardest situations to reach from the ports are the early terminations and the pointer found at the last level, because each needs a table tree with a specific shape. The bench builds a sparse memory image in which neighbouring index values inside shared tables lead to a level-3 leaf, a level-2 leaf, a level-1 leaf, an empty slot, a reserved type and a level-3 pointer. A small reference walk over the same image predicts every read address and result. Memory back-pressure is exercised by toggling `mem_req_ready` each cycle. Ignored misses are exercised by presenting `miss_valid` with a different page number throughout a busy walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int L1_W   = 8;
  localparam int L2_W   = 6;
  localparam int L3_W   = 6;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = L1_W + L2_W + L3_W;
  localparam int PA_W   = 32;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int PTE_W  = 32;
  localparam int PERM_W = 10;
  localparam int CTX_W  = 8;
  localparam int LVL_W  = 2;

  typedef enum logic [1:0] {
    ET_INVALID = 2'b00,
    ET_POINTER = 2'b01,
    ET_LEAF    = 2'b10,
    ET_RSVD    = 2'b11
  } etype_t;

  typedef enum logic [1:0] {
    WS_IDLE = 2'b00,
    WS_REQ  = 2'b01,
    WS_WAIT = 2'b10
  } wstate_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int P_L1_W  = L1_W,
  parameter int P_L2_W  = L2_W,
  parameter int P_L3_W  = L3_W,
  parameter int P_CTX_W = CTX_W,
  parameter int P_PA_W  = PA_W,
  localparam int P_VPN_W = P_L1_W + P_L2_W + P_L3_W
) (
  input  logic [1:0]         lvl,
  input  logic [P_VPN_W-1:0] vpn,
  input  logic [P_CTX_W-1:0] ctx,
  input  logic [P_PA_W-1:0]  base,
  output logic [P_PA_W-1:0]  addr
);
  logic [P_PA_W-1:0] idx_ext;

  always_comb begin
    idx_ext = '0;
    case (lvl)
      2'd0: idx_ext[P_CTX_W-1:0] = ctx;
      2'd1: idx_ext[P_L1_W-1:0]  = vpn[P_VPN_W-1 -: P_L1_W];
      2'd2: idx_ext[P_L2_W-1:0]  = vpn[P_L2_W+P_L3_W-1 -: P_L2_W];
      default: idx_ext[P_L3_W-1:0] = vpn[P_L3_W-1:0];
    endcase
  end

  assign addr = base + (idx_ext << 2);
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int P_L2_W   = L2_W,
  parameter int P_L3_W   = L3_W,
  parameter int P_VPN_W  = VPN_W,
  parameter int P_PPN_W  = PPN_W,
  parameter int P_PTE_W  = PTE_W,
  parameter int P_PA_W   = PA_W,
  parameter int P_PERM_W = PERM_W
) (
  input  logic [P_PTE_W-1:0]  pte,
  input  logic [1:0]          lvl,
  input  logic [P_VPN_W-1:0]  vpn,
  output logic                descend,
  output logic                leaf,
  output logic [P_PA_W-1:0]   next_base,
  output logic [P_PPN_W-1:0]  ppn,
  output logic [P_PERM_W-1:0] perm
);
  etype_t              et;
  logic [P_PPN_W-1:0]  keep_mask;
  logic [P_PPN_W-1:0]  vpn_ext;

  assign et        = etype_t'(pte[1:0]);
  assign descend   = (et == ET_POINTER) && (lvl != 2'd3);
  assign leaf      = (et == ET_LEAF) && (lvl != 2'd0);
  assign next_base = {pte[P_PA_W-1:2], 2'b00};
  assign perm      = pte[P_PERM_W+1:2];
  assign vpn_ext   = P_PPN_W'(vpn);

  // Index bits not consumed by the walk are copied from the VPN.
  always_comb begin
    case (lvl)
      2'd1:    keep_mask = {{(P_PPN_W-P_L2_W-P_L3_W){1'b0}}, {(P_L2_W+P_L3_W){1'b1}}};
      2'd2:    keep_mask = {{(P_PPN_W-P_L3_W){1'b0}}, {P_L3_W{1'b1}}};
      default: keep_mask = '0;
    endcase
  end

  assign ppn = (pte[P_PTE_W-1 -: P_PPN_W] & ~keep_mask) | (vpn_ext & keep_mask);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   ctx_table_base,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [VPN_W-1:0]  miss_vpn,
  input  logic [CTX_W-1:0]  miss_ctx,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              refill_valid,
  output logic [PPN_W-1:0]  refill_ppn,
  output logic [PERM_W-1:0] refill_perm,
  output logic [LVL_W-1:0]  refill_level,
  output logic              fault_valid,
  output logic [LVL_W-1:0]  fault_level
);
  wstate_t             state_q, state_d;
  logic [1:0]          lvl_q, lvl_d;
  logic [PA_W-1:0]     base_q, base_d;
  logic [VPN_W-1:0]    vpn_q;
  logic [CTX_W-1:0]    ctx_q;
  logic                capture;
  logic                done_d, fault_d;
  logic                refill_q, fault_q;
  logic [PPN_W-1:0]    ppn_q;
  logic [PERM_W-1:0]   perm_q;
  logic [1:0]          end_lvl_q;

  logic                dec_descend, dec_leaf;
  logic [PA_W-1:0]     dec_next_base;
  logic [PPN_W-1:0]    dec_ppn;
  logic [PERM_W-1:0]   dec_perm;

  ptw_addr_gen u_addr (
    .lvl  (lvl_q),
    .vpn  (vpn_q),
    .ctx  (ctx_q),
    .base (base_q),
    .addr (mem_req_addr)
  );

  ptw_pte_decode u_dec (
    .pte       (mem_rsp_data),
    .lvl       (lvl_q),
    .vpn       (vpn_q),
    .descend   (dec_descend),
    .leaf      (dec_leaf),
    .next_base (dec_next_base),
    .ppn       (dec_ppn),
    .perm      (dec_perm)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    capture = 1'b0;
    done_d  = 1'b0;
    fault_d = 1'b0;
    case (state_q)
      WS_IDLE: begin
        if (miss_valid) begin
          capture = 1'b1;
          lvl_d   = 2'd0;
          base_d  = ctx_table_base;
          state_d = WS_REQ;
        end
      end
      WS_REQ: begin
        if (mem_req_ready) state_d = WS_WAIT;
      end
      WS_WAIT: begin
        if (mem_rsp_valid) begin
          if (dec_descend) begin
            lvl_d   = lvl_q + 2'd1;
            base_d  = dec_next_base;
            state_d = WS_REQ;
          end else if (dec_leaf) begin
            done_d  = 1'b1;
            state_d = WS_IDLE;
          end else begin
            fault_d = 1'b1;
            state_d = WS_IDLE;
          end
        end
      end
      default: state_d = WS_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WS_IDLE;
      lvl_q     <= 2'd0;
      base_q    <= '0;
      vpn_q     <= '0;
      ctx_q     <= '0;
      refill_q  <= 1'b0;
      fault_q   <= 1'b0;
      ppn_q     <= '0;
      perm_q    <= '0;
      end_lvl_q <= 2'd0;
    end else begin
      state_q  <= state_d;
      lvl_q    <= lvl_d;
      base_q   <= base_d;
      refill_q <= done_d;
      fault_q  <= fault_d;
      if (capture) begin
        vpn_q <= miss_vpn;
        ctx_q <= miss_ctx;
      end
      if (done_d) begin
        ppn_q  <= dec_ppn;
        perm_q <= dec_perm;
      end
      if (done_d || fault_d) end_lvl_q <= lvl_q;
    end
  end

  assign miss_ready    = (state_q == WS_IDLE);
  assign mem_req_valid = (state_q == WS_REQ);
  assign refill_valid  = refill_q;
  assign refill_ppn    = ppn_q;
  assign refill_perm   = perm_q;
  assign refill_level  = end_lvl_q;
  assign fault_valid   = fault_q;
  assign fault_level   = end_lvl_q;
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk
  import ptw_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            miss_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            refill_valid,
  input logic [1:0]      refill_level,
  input logic            fault_valid
);
  logic inflight_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              inflight_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) inflight_q <= 1'b1;
    else if (mem_rsp_valid)                  inflight_q <= 1'b0;
  end

  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_word_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q |-> !mem_req_valid);

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || inflight_q) |-> !miss_ready);

  assert_end_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(refill_valid && fault_valid));

  assert_refill_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |=> !refill_valid);

  assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);

  assert_leaf_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |-> (refill_level != 2'd0));
endmodule

bind pt_walker ptw_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_ready    (miss_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .refill_valid  (refill_valid),
  .refill_level  (refill_level),
  .fault_valid   (fault_valid)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] ctx_table_base;
  logic        miss_valid;
  logic        miss_ready;
  logic [19:0] miss_vpn;
  logic [7:0]  miss_ctx;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        refill_valid;
  logic [19:0] refill_ppn;
  logic [9:0]  refill_perm;
  logic [1:0]  refill_level;
  logic        fault_valid;
  logic [1:0]  fault_level;

  int vectors = 0;
  int errors  = 0;
  bit bp_en   = 0;
  int rd_total;
  logic [31:0] rd_log [0:255];
  logic [31:0] mem [logic [31:0]];

  localparam logic [31:0] CTX_BASE = 32'h0001_0000;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .ctx_table_base(ctx_table_base),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_vpn(miss_vpn), .miss_ctx(miss_ctx),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .refill_valid(refill_valid), .refill_ppn(refill_ppn), .refill_perm(refill_perm),
    .refill_level(refill_level), .fault_valid(fault_valid), .fault_level(fault_level)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // Memory model: one-cycle read latency, optional ready toggling
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      mem_req_ready <= 1'b1;
      rd_total      <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_rd(mem_req_addr);
        rd_log[rd_total[7:0]] <= mem_req_addr;
        rd_total <= rd_total + 1;
      end
      mem_req_ready <= bp_en ? ~mem_req_ready : 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  // Independent reference walk over the memory image
  task automatic ref_walk(input logic [19:0] vpn, input logic [7:0] ctx,
                          output bit flt, output logic [1:0] lvl,
                          output logic [19:0] ppn, output logic [9:0] perm,
                          output int n, output logic [31:0] adr [4]);
    logic [31:0] e, base, a;
    logic [7:0]  idx;
    int keep;
    flt = 1; lvl = 0; ppn = '0; perm = '0; n = 0;
    for (int i = 0; i < 4; i++) adr[i] = '0;
    a = CTX_BASE + {22'd0, ctx, 2'b00};
    adr[0] = a; n = 1; e = mem_rd(a);
    if (e[1:0] != 2'b01) return;
    base = {e[31:2], 2'b00};
    for (int l = 1; l <= 3; l++) begin
      idx = (l == 1) ? vpn[19:12] : (l == 2) ? {2'b00, vpn[11:6]} : {2'b00, vpn[5:0]};
      a = base + {22'd0, idx, 2'b00};
      adr[n] = a; n++; e = mem_rd(a);
      lvl = 2'(l);
      if (e[1:0] == 2'b10) begin
        keep = (l == 1) ? 12 : (l == 2) ? 6 : 0;
        ppn  = (e[31:12] & ~20'((1 << keep) - 1)) | (vpn & 20'((1 << keep) - 1));
        perm = e[11:2];
        flt  = 0;
        return;
      end
      if (e[1:0] != 2'b01 || l == 3) return;
      base = {e[31:2], 2'b00};
    end
  endtask

  task automatic run_walk(input logic [19:0] vpn, input logic [7:0] ctx,
                          input string req, input bit noise);
    bit exp_flt; logic [1:0] exp_lvl; logic [19:0] exp_ppn; logic [9:0] exp_perm;
    int exp_n; logic [31:0] exp_adr [4];
    int start, cyc; bit got_ref, got_flt, busy_ok;
    ref_walk(vpn, ctx, exp_flt, exp_lvl, exp_ppn, exp_perm, exp_n, exp_adr);
    @(negedge clk);
    start = rd_total;
    check(miss_ready == 1'b1, "R2", "ready before miss", 32'(miss_ready), 1);
    miss_valid = 1; miss_vpn = vpn; miss_ctx = ctx;
    @(negedge clk);
    miss_valid = 0;
    cyc = 0; busy_ok = 1;
    while (!(refill_valid || fault_valid) && cyc < 200) begin
      if (miss_ready) busy_ok = 0;
      if (noise) begin miss_valid = 1; miss_vpn = ~vpn; miss_ctx = ctx ^ 8'h1; end
      @(negedge clk);
      cyc++;
    end
    miss_valid = 0;
    got_ref = refill_valid; got_flt = fault_valid;
    check(busy_ok, "R2", "miss_ready low while busy", 32'(busy_ok), 1);
    check(got_flt == exp_flt && got_ref == !exp_flt, req, "end kind (fault)",
          32'(got_flt), 32'(exp_flt));
    if (!exp_flt) begin
      check(refill_ppn == exp_ppn, req, "refill_ppn", 32'(refill_ppn), 32'(exp_ppn));
      check(refill_perm == exp_perm, req, "refill_perm", 32'(refill_perm), 32'(exp_perm));
      check(refill_level == exp_lvl, req, "refill_level", 32'(refill_level), 32'(exp_lvl));
    end else begin
      check(fault_level == exp_lvl, req, "fault_level", 32'(fault_level), 32'(exp_lvl));
    end
    check(rd_total - start == exp_n, req, "read count", 32'(rd_total - start), 32'(exp_n));
    for (int i = 0; i < exp_n && i < 4; i++)
      check(rd_log[8'(start + i)] == exp_adr[i], "R4", "read address",
            rd_log[8'(start + i)], exp_adr[i]);
    @(negedge clk);
    check(!refill_valid && !fault_valid, "R10", "pulse is one cycle",
          32'({refill_valid, fault_valid}), 0);
    if (noise) begin
      start = rd_total;
      repeat (3) @(negedge clk);
      check(rd_total == start && !mem_req_valid, "R2", "ignored miss started no read",
            32'(rd_total - start), 0);
    end
  endtask

  // Scenario tasks
  task automatic t_reset();
    check(miss_ready == 1'b1, "R1", "miss_ready", 32'(miss_ready), 1);
    check(!mem_req_valid, "R1", "mem_req_valid", 32'(mem_req_valid), 0);
    check(!refill_valid && !fault_valid, "R1", "pulses", 32'({refill_valid, fault_valid}), 0);
  endtask

  task automatic t_full_walk();
    run_walk({8'h12, 6'h05, 6'h2A}, 8'd3, "R6", 0);
    check(refill_ppn == 20'hABCDE, "R6", "hand ppn", 32'(refill_ppn), 32'hABCDE);
  endtask

  task automatic t_l2_leaf();
    run_walk({8'h12, 6'h07, 6'h11}, 8'd3, "R7", 0);
    check(refill_ppn == {14'h1555, 6'h11}, "R7", "hand l2 ppn", 32'(refill_ppn),
          32'({14'h1555, 6'h11}));
  endtask

  task automatic t_l1_leaf();
    run_walk({8'h40, 6'h33, 6'h0C}, 8'd3, "R7", 0);
    check(refill_ppn == {8'hC3, 12'hCCC}, "R7", "hand l1 ppn", 32'(refill_ppn),
          32'({8'hC3, 12'hCCC}));
  endtask

  task automatic t_faults();
    run_walk({8'h12, 6'h09, 6'h00}, 8'd3, "R5", 0);
    check(fault_level == 2'd2, "R5", "hand invalid level", 32'(fault_level), 2);
    run_walk({8'h41, 6'h00, 6'h00}, 8'd3, "R5", 0);
    run_walk({8'h12, 6'h05, 6'h3F}, 8'd3, "R8", 0);
    check(fault_level == 2'd3, "R8", "hand ptr at L3", 32'(fault_level), 3);
    run_walk({8'h12, 6'h05, 6'h2A}, 8'd5, "R3", 0);
    run_walk({8'h12, 6'h05, 6'h2A}, 8'd6, "R3", 0);
    check(fault_level == 2'd0, "R3", "hand ctx fault", 32'(fault_level), 0);
  endtask

  task automatic t_context();
    run_walk({8'h12, 6'h05, 6'h2A}, 8'd4, "R3", 0);
    check(refill_ppn == 20'h0F00D, "R3", "ctx 4 root", 32'(refill_ppn), 32'h0F00D);
  endtask

  task automatic t_backpressure();
    bp_en = 1;
    run_walk({8'h12, 6'h05, 6'h2A}, 8'd3, "R9", 0);
    bp_en = 0;
  endtask

  task automatic t_busy_ignore();
    run_walk({8'h12, 6'h05, 6'h2A}, 8'd3, "R2", 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    rst_n = 0; miss_valid = 0; miss_vpn = '0; miss_ctx = '0;
    ctx_table_base = CTX_BASE;
    // Context table
    mem[CTX_BASE + 3*4] = 32'h0002_0001;
    mem[CTX_BASE + 4*4] = 32'h0006_0001;
    mem[CTX_BASE + 5*4] = 32'h0002_0002;
    // Context 3 tree
    mem[32'h0002_0000 + 32'h12*4] = 32'h0003_0001;
    mem[32'h0002_0000 + 32'h40*4] = {8'hC3, 12'h000, 10'h0AA, 2'b10};
    mem[32'h0002_0000 + 32'h41*4] = 32'h0007_0003;
    mem[32'h0003_0000 + 32'h05*4] = 32'h0004_0001;
    mem[32'h0003_0000 + 32'h07*4] = {14'h1555, 6'h3F, 10'h21F, 2'b10};
    mem[32'h0004_0000 + 32'h2A*4] = {20'hABCDE, 10'h155, 2'b10};
    mem[32'h0004_0000 + 32'h3F*4] = 32'h0005_0001;
    // Context 4 tree
    mem[32'h0006_0000 + 32'h12*4] = 32'h0008_0001;
    mem[32'h0008_0000 + 32'h05*4] = 32'h0009_0001;
    mem[32'h0009_0000 + 32'h2A*4] = {20'h0F00D, 10'h3C1, 2'b10};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_walk();
    t_l2_leaf();
    t_l1_leaf();
    t_faults();
    t_context();
    t_backpressure();
    t_busy_ignore();
    report();
  end
endmodule